// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block is the programmable feedback divider of an integer-N synthesizer. A fast input clock goes through a dual-modulus prescaler. The prescaler counts either P or P+1 input cycles per output tick, and its base P is chosen as 5 or 10. A swallow counter keeps the prescaler at P+1 for the first A ticks of each output period. A main counter ends the period after M+1 ticks. The total ratio is P·(M+1)+A. When the active-low prescaler enable is driven high, the prescaler is held idle and the swallow value is ignored, so the input is divided by M+1 alone.

All logic runs on the input clock and creates no derived clock. The block emits one registered pulse, one input cycle wide, per completed period. The settings (enable, base select, M, A) are captured only on the edge that closes a period. Retuning mid-period therefore never produces a shortened or stretched period. A synchronous reset clears every counter. It also captures the current settings, so a fresh period starts on the first edge after reset.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With `pre_en_n`=0 and `base_sel`=1, the spacing between output pulses is 10·(M+1)+A input cycles, for legal A ≤ M+1.
- R2: With `pre_en_n`=0 and `base_sel`=0, the spacing between output pulses is 5·(M+1)+A input cycles, for legal A ≤ M+1.
- R3: `fp_out` is high for exactly one input cycle per period, and consecutive pulses are exactly one period apart.
- R4: While `rst` is high, and in the first cycle after it, `fp_out` is low. Settings present at the last reset edge govern the first period, and its pulse follows the Nth rising edge after reset is released, where N is the ratio.
- R5: Settings are captured only on the rising edge that ends a period, which is the edge after which `fp_out` goes high. A change applied earlier in a period, including in its final cycle, affects only the following period.
- R6: With `pre_en_n`=1, the ratio is M+1, and neither `swallow_a` (any of 0..15) nor `base_sel` has any effect.
- R7: Boundary ratios hold: M=1 in bypass gives 2; A=0 gives exactly P·(M+1); A=M+1 gives P·(M+1)+M+1; M=511 with the base of 10 gives 5120+A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| pre_en_n | input | 1 | Prescaler enable, active low; 1 selects bypass |
| base_sel | input | 1 | Prescaler base: 1 selects 10/11, 0 selects 5/6 |
| main_m | input | 9 | Main counter value M, legal 1..511 |
| swallow_a | input | 4 | Swallow count A, 0..15, legal when A ≤ M+1 |
| fp_out | output | 1 | One-cycle pulse per division period |

## Verification
Two functions can fall in the same cycle: the period-ending reload of the working counters, and an external change of the settings. The bench applies a new setting in the last cycle of a period. That setting must govern the very next period. It also applies a setting just after a pulse, and that setting must leave the current period untouched. Both cases are judged by counting input cycles between successive pulses and comparing the counts with P·(M+1)+A or M+1, computed from the values in force. Sweeps over M and A for both bases and for bypass cover the swallow and main-counter terminal conditions, including the cycles where both counters finish together.

// File: rtl/ps_div_pkg.sv
package ps_div_pkg;
  localparam int unsigned BASE_LO = 5;
  localparam int unsigned BASE_HI = 10;
  localparam int unsigned PC_W    = $clog2(BASE_HI + 2);

  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } base_sel_e;
endpackage

// File: rtl/ps_prescaler.sv
module ps_prescaler
  import ps_div_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      idle,
  input  base_sel_e base,
  input  logic      swallow,
  output logic      tick
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] base_val;
  logic [PC_W-1:0] last_val;

  assign base_val = (base == SEL_HIGH) ? PC_W'(BASE_HI) : PC_W'(BASE_LO);
  assign last_val = base_val + PC_W'(swallow) - PC_W'(1);
  assign tick     = idle | (pc_q == last_val);

  always_ff @(posedge clk) begin
    if (rst || idle || tick) pc_q <= '0;
    else                     pc_q <= pc_q + PC_W'(1);
  end

  // R1 / R2: the count never passes the current modulus
  assert_pc_bound_R1: assert property (@(posedge clk) disable iff (rst)
    !idle |-> (pc_q <= last_val));

  // R6: the idle prescaler stays parked at zero
  assert_idle_parked_R6: assert property (@(posedge clk) disable iff (rst)
    idle |-> (pc_q == '0));

  // R2: the modulus control changes only on a prescaler tick
  assert_mod_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick)) |-> $stable(swallow));
endmodule

// File: rtl/ps_chain_ctrl.sv
module ps_chain_ctrl
  import ps_div_pkg::*;
#(
  parameter int unsigned M_W = 9,
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_en_n,
  input  logic           base_sel,
  input  logic [M_W-1:0] main_m,
  input  logic [A_W-1:0] swallow_a,
  input  logic           tick,
  output logic           swallow,
  output base_sel_e      base,
  output logic           idle,
  output logic           end_p
);
  typedef struct packed {
    logic           bypass;
    base_sel_e      base;
    logic [M_W-1:0] m_lim;
    logic [A_W-1:0] a_lim;
  } cfg_t;

  cfg_t           cfg_q;
  logic [M_W-1:0] m_cnt_q;
  logic [A_W-1:0] a_cnt_q;

  assign idle    = cfg_q.bypass;
  assign base    = cfg_q.base;
  assign swallow = (a_cnt_q != cfg_q.a_lim);
  assign end_p   = tick && (m_cnt_q == cfg_q.m_lim);

  always_ff @(posedge clk) begin
    if (rst || end_p) begin
      m_cnt_q      <= '0;
      a_cnt_q      <= '0;
      cfg_q.bypass <= pre_en_n;
      cfg_q.base   <= base_sel ? SEL_HIGH : SEL_LOW;
      cfg_q.m_lim  <= main_m;
      cfg_q.a_lim  <= pre_en_n ? '0 : swallow_a;
    end else if (tick) begin
      m_cnt_q <= m_cnt_q + M_W'(1);
      if (swallow) a_cnt_q <= a_cnt_q + A_W'(1);
    end
  end

  // R5: settings are held for the whole period
  assert_cfg_held_R5: assert property (@(posedge clk) disable iff (rst)
    !end_p |=> ($stable(cfg_q.m_lim) && $stable(cfg_q.a_lim) && $stable(cfg_q.base)
                && $stable(cfg_q.bypass)));

  // R1: with A <= M every swallow is spent before the period closes
  assert_swallow_done_R1: assert property (@(posedge clk) disable iff (rst)
    (end_p && (int'(cfg_q.a_lim) <= int'(cfg_q.m_lim))) |-> (a_cnt_q == cfg_q.a_lim));

  // R3: no back-to-back period ends for a legal M
  assert_single_end_R3: assert property (@(posedge clk) disable iff (rst)
    end_p |=> (!end_p || cfg_q.m_lim == '0));

  // R6: bypass never swallows
  assert_bypass_noswallow_R6: assert property (@(posedge clk) disable iff (rst)
    idle |-> !swallow);
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import ps_div_pkg::*;
#(
  parameter int unsigned M_W = 9,
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_en_n,
  input  logic           base_sel,
  input  logic [M_W-1:0] main_m,
  input  logic [A_W-1:0] swallow_a,
  output logic           fp_out
);
  logic      tick;
  logic      swallow;
  logic      idle;
  logic      end_p;
  base_sel_e base;

  ps_prescaler u_presc (
    .clk     (clk),
    .rst     (rst),
    .idle    (idle),
    .base    (base),
    .swallow (swallow),
    .tick    (tick)
  );

  ps_chain_ctrl #(.M_W(M_W), .A_W(A_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pre_en_n  (pre_en_n),
    .base_sel  (base_sel),
    .main_m    (main_m),
    .swallow_a (swallow_a),
    .tick      (tick),
    .swallow   (swallow),
    .base      (base),
    .idle      (idle),
    .end_p     (end_p)
  );

  always_ff @(posedge clk) begin
    if (rst) fp_out <= 1'b0;
    else     fp_out <= end_p;
  end

  // R4: the output is quiet on the first cycle out of reset
  assert_reset_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fp_out);
endmodule

// File: tb/pulse_swallow_divider_tb_top.sv
`timescale 1ns/1ps
module pulse_swallow_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pre_en_n = 1'b0;
  logic       base_sel = 1'b1;
  logic [8:0] main_m = 9'd1;
  logic [3:0] swallow_a = 4'd0;
  logic       fp_out;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pulse_swallow_divider dut_i (
    .clk(clk), .rst(rst), .pre_en_n(pre_en_n), .base_sel(base_sel),
    .main_m(main_m), .swallow_a(swallow_a), .fp_out(fp_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 195000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input bit en_n, input bit sel, input int m, input int a);
    if (en_n) return m + 1;
    return (sel ? 10 : 5) * (m + 1) + a;
  endfunction

  task automatic apply(input bit en_n, input bit sel, input int m, input int a);
    pre_en_n  = en_n;
    base_sel  = sel;
    main_m    = 9'(m);
    swallow_a = 4'(a);
  endtask

  // counts negedges from 'start' until fp_out is seen high
  task automatic wait_fp(input int start, output int n);
    n = start;
    do begin
      @(negedge clk);
      n++;
    end while (!fp_out && n < 6000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(fp_out == 1'b0, "R4 fp low in reset", int'(fp_out), 0);
    rst = 1'b0;
  endtask

  // reset, then check first period, pulse width and second period
  task automatic run_cfg(input bit en_n, input bit sel, input int m, input int a,
                         input string req);
    int n;
    int exp;
    exp = ratio(en_n, sel, m, a);
    apply(en_n, sel, m, a);
    do_reset();
    wait_fp(0, n);
    check(n == exp, {req, " R4 first period"}, n, exp);
    @(negedge clk);
    check(fp_out == 1'b0, "R3 single-cycle pulse", int'(fp_out), 0);
    wait_fp(1, n);
    check(n == exp, {req, " R3 spacing"}, n, exp);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(fp_out == 1'b0, "R4 reset state", int'(fp_out), 0);

    // R1: base 10 sweep, all legal A
    for (int m = 1; m <= 8; m++)
      for (int a = 0; a <= m + 1 && a <= 15; a++)
        run_cfg(1'b0, 1'b1, m, a, "R1");

    // R2: base 5 sweep, all legal A
    for (int m = 1; m <= 14; m++)
      for (int a = 0; a <= m + 1 && a <= 15; a++)
        run_cfg(1'b0, 1'b0, m, a, "R2");

    // R7: boundaries
    run_cfg(1'b1, 1'b0, 1, 0, "R7 bypass M=1");
    run_cfg(1'b0, 1'b1, 511, 0, "R7 M=511 A=0");
    run_cfg(1'b0, 1'b1, 511, 15, "R7 M=511 A=15");
    run_cfg(1'b0, 1'b0, 14, 15, "R7 A=M+1");
    run_cfg(1'b0, 1'b1, 9, 0, "R7 A=0");

    // R6: bypass sweep and ignored swallow/base inputs
    for (int m = 1; m <= 32; m++)
      run_cfg(1'b1, 1'(m % 2), m, m % 16, "R6 sweep");
    for (int a = 0; a <= 15; a++)
      for (int s = 0; s <= 1; s++)
        run_cfg(1'b1, 1'(s), 9, a, "R6 ignored inputs");
    run_cfg(1'b1, 1'b1, 511, 7, "R6 M=511");

    // R5: change just after a pulse, then in the final cycle of a period
    apply(1'b0, 1'b1, 3, 2);
    do_reset();
    wait_fp(0, n);
    check(n == 42, "R5 first period", n, 42);
    apply(1'b0, 1'b0, 4, 1);
    wait_fp(0, n);
    check(n == 42, "R5 mid-period change ignored", n, 42);
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      if (fp_out) check(1'b0, "R5 early pulse", k, 26);
    end
    apply(1'b1, 1'b1, 6, 9);
    wait_fp(25, n);
    check(n == 26, "R5 period with final-cycle change", n, 26);
    wait_fp(0, n);
    check(n == 7, "R5 final-cycle change taken", n, 7);
    wait_fp(0, n);
    check(n == 7, "R5 new setting persists", n, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule